// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Counter with State Decoder

This block is a twisted-ring (Johnson) counter of N stages, four by default. On every enabled clock the register shifts one place toward its top stage. The new bottom bit is the complement of the top stage, so the register first fills with ones and then drains back to zeros. This gives a cycle of 2N states in which exactly one flip-flop changes per step.

The feedback carries an extra correction term. The term agrees with plain twisted-ring feedback on every cycle state. On an unused power-up or corrupted pattern, the term steers the register into the main cycle within a few clocks, so no closed loop of unused states exists.

Each cycle state is decoded by a single two-input AND on one pair of neighbouring stages. The decode vector is therefore one-hot and free of false pulses while the counter is in the cycle. A flag reports whether the register holds a cycle state. The top stage serves as a tap that divides the clock by 2N. A synchronous parallel load seeds the register with any pattern, so start-up faults can be reproduced.

Top module: `johnson_sc`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) clears the register to all zeros. It takes priority over load and enable. After reset `valid_o` is 1 and only `dec_o[0]` is high.
- R2: With `en_i` high and no reset or load, each stage k+1 takes the old value of stage k on the clock edge. Stage 0 takes the feedback bit.
- R3: On cycle states the feedback bit is the complement of the old top stage. For N=4 the sequence from 0000 is 0001, 0011, 0111, 1111, 1110, 1100, 1000 and then back to 0000.
- R4: With `en_i` low and no reset or load, the register holds its value. The decode outputs, the flag and the tap follow the held state.
- R5: `load_i` high (without reset) places `load_val_i` in the register on the next edge, whatever `en_i` is.
- R6: For N=4 the feedback is ~Q3 & (Q0 | ~Q2). Every unused pattern reaches the cycle within 5 enabled clocks, and 1001 takes exactly 5 (1001, 0010, 0101, 1011, 0110, 1100).
- R7: `dec_o[k]` is high in the k-th cycle state, counting 0000 as k=0. For N=4: 0000→0, 0001→1, 0011→2, 0111→3, 1111→4, 1110→5, 1100→6, 1000→7. On every cycle state exactly one decode bit is high.
- R8: `valid_o` is high exactly when the register holds one of the 2N cycle states, that is, when at most one adjacent stage pair differs.
- R9: Within the cycle, each enabled clock changes exactly one register bit.
- R10: `div_o` is the top stage. Counting from reset, it is high for N enabled clocks and low for N, giving a period of 2N clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Count enable |
| load_i | input | 1 | Synchronous parallel load strobe |
| load_val_i | input | N | Pattern placed in the register on load |
| count_o | output | N | Raw register, bit 0 receives the feedback |
| dec_o | output | 2N | One-hot decoded cycle state |
| valid_o | output | 1 | High when the register holds a cycle state |
| div_o | output | 1 | Clock divided by 2N (top stage) |

## Verification
The bench builds the counter with its default N=4. At that width all 16 register patterns can be seeded through the load port. Each unused pattern is then walked until it rejoins the cycle, with the step count compared against a precomputed table. The same width makes the full 8-state order, the decode index of every cycle state and the 8-clock tap period small enough to check step by step.

// File: rtl/johnson_sc_pkg.sv
package johnson_sc_pkg;

    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_SHIFT = 2'd1,
        SRC_LOAD  = 2'd2,
        SRC_CLEAR = 2'd3
    } next_src_e;

    localparam int unsigned MIN_STAGES = 2;

endpackage

// File: rtl/johnson_sc_feedback.sv
module johnson_sc_feedback #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] q_i,
    output logic         fb_o
);
    logic plain_fb;
    logic keep_term;

    always_comb begin
        plain_fb  = ~q_i[N-1];
        // stays 1 on every cycle state whose top stage is 0
        keep_term = q_i[0] | ~q_i[N-2];
        fb_o      = plain_fb & keep_term;
    end
endmodule

// File: rtl/johnson_sc_decode.sv
module johnson_sc_decode #(
    parameter int unsigned N = 4,
    localparam int unsigned S = 2 * N
) (
    input  logic [N-1:0] q_i,
    output logic [S-1:0] dec_o
);
    for (genvar k = 0; k < S; k++) begin : g_term
        if (k == 0) begin : g_empty
            assign dec_o[k] = ~q_i[N-1] & ~q_i[0];
        end else if (k < N) begin : g_fill
            assign dec_o[k] = q_i[k-1] & ~q_i[k];
        end else if (k == N) begin : g_full
            assign dec_o[k] = q_i[N-1] & q_i[0];
        end else begin : g_drain
            assign dec_o[k] = ~q_i[k-N-1] & q_i[k-N];
        end
    end
endmodule

// File: rtl/johnson_sc_valid.sv
module johnson_sc_valid #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] q_i,
    output logic         valid_o
);
    logic [N-2:0]          edges;
    logic [$clog2(N):0]    n_edges;

    always_comb begin
        edges   = q_i[N-1:1] ^ q_i[N-2:0];
        n_edges = '0;
        for (int i = 0; i < N - 1; i++) begin
            n_edges = n_edges + {{$clog2(N){1'b0}}, edges[i]};
        end
        valid_o = (n_edges <= 1);
    end
endmodule

// File: rtl/johnson_sc.sv
module johnson_sc
    import johnson_sc_pkg::*;
#(
    parameter int unsigned N = 4,
    localparam int unsigned S = 2 * N
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    input  logic         load_i,
    input  logic [N-1:0] load_val_i,
    output logic [N-1:0] count_o,
    output logic [S-1:0] dec_o,
    output logic         valid_o,
    output logic         div_o
);
    typedef struct packed {
        logic [N-1:0] ring;
    } state_t;

    state_t    st_d, st_q;
    next_src_e src_d;
    logic      fb_d;

    johnson_sc_feedback #(.N(N)) u_fb (
        .q_i  (st_q.ring),
        .fb_o (fb_d)
    );

    johnson_sc_decode #(.N(N)) u_dec (
        .q_i   (st_q.ring),
        .dec_o (dec_o)
    );

    johnson_sc_valid #(.N(N)) u_val (
        .q_i     (st_q.ring),
        .valid_o (valid_o)
    );

    always_comb begin
        if (rst_i)       src_d = SRC_CLEAR;
        else if (load_i) src_d = SRC_LOAD;
        else if (en_i)   src_d = SRC_SHIFT;
        else             src_d = SRC_HOLD;

        st_d = st_q;
        unique case (src_d)
            SRC_CLEAR: st_d.ring = '0;
            SRC_LOAD:  st_d.ring = load_val_i;
            SRC_SHIFT: st_d.ring = {st_q.ring[N-2:0], fb_d};
            default:   st_d.ring = st_q.ring;
        endcase
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign count_o = st_q.ring;
    assign div_o   = st_q.ring[N-1];
endmodule

// File: rtl/johnson_sc_chk.sv
module johnson_sc_chk #(
    parameter int unsigned N = 4,
    localparam int unsigned S = 2 * N
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         en_i,
    input logic         load_i,
    input logic [N-1:0] load_val_i,
    input logic [N-1:0] count_o,
    input logic [S-1:0] dec_o,
    input logic         valid_o
);
    p_reset_clears_r1: assert property (@(posedge clk_i)
        rst_i |=> (count_o == '0));

    p_shift_moves_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && en_i) |=> (count_o[N-1:1] == $past(count_o[N-2:0])));

    p_plain_feedback_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && en_i && valid_o) |=> (count_o[0] == !$past(count_o[N-1])));

    p_hold_stable_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && !en_i) |=> $stable(count_o));

    p_load_takes_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (count_o == $past(load_val_i)));

    p_decode_onehot_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> ($countones(dec_o) == 1));

    p_cycle_closed_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && valid_o) |=> valid_o);

    p_one_bit_step_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && en_i && valid_o) |=> ($countones(count_o ^ $past(count_o)) == 1));
endmodule

bind johnson_sc johnson_sc_chk #(.N(N)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .en_i       (en_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .count_o    (count_o),
    .dec_o      (dec_o),
    .valid_o    (valid_o)
);

// File: tb/johnson_sc_test.sv
`timescale 1ns/1ps
module johnson_sc_test;
    localparam int unsigned N = 4;
    localparam int unsigned S = 2 * N;

    logic         clk = 1'b0;
    logic         rst_i = 1'b1;
    logic         en_i = 1'b0;
    logic         load_i = 1'b0;
    logic [N-1:0] load_val_i = '0;
    logic [N-1:0] count_o;
    logic [S-1:0] dec_o;
    logic         valid_o;
    logic         div_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    johnson_sc #(.N(N)) uut (
        .clk_i(clk), .rst_i(rst_i), .en_i(en_i), .load_i(load_i),
        .load_val_i(load_val_i), .count_o(count_o), .dec_o(dec_o),
        .valid_o(valid_o), .div_o(div_o)
    );

    // {start[3:0], next[3:0], steps_to_cycle[2:0], valid, dec_index[2:0]}
    localparam logic [14:0] VEC [16] = '{
        {4'b0000, 4'b0001, 3'd0, 1'b1, 3'd0},
        {4'b0001, 4'b0011, 3'd0, 1'b1, 3'd1},
        {4'b0010, 4'b0101, 3'd4, 1'b0, 3'd0},
        {4'b0011, 4'b0111, 3'd0, 1'b1, 3'd2},
        {4'b0100, 4'b1000, 3'd1, 1'b0, 3'd0},
        {4'b0101, 4'b1011, 3'd3, 1'b0, 3'd0},
        {4'b0110, 4'b1100, 3'd1, 1'b0, 3'd0},
        {4'b0111, 4'b1111, 3'd0, 1'b1, 3'd3},
        {4'b1000, 4'b0000, 3'd0, 1'b1, 3'd7},
        {4'b1001, 4'b0010, 3'd5, 1'b0, 3'd0},
        {4'b1010, 4'b0100, 3'd2, 1'b0, 3'd0},
        {4'b1011, 4'b0110, 3'd2, 1'b0, 3'd0},
        {4'b1100, 4'b1000, 3'd0, 1'b1, 3'd6},
        {4'b1101, 4'b1010, 3'd3, 1'b0, 3'd0},
        {4'b1110, 4'b1100, 3'd0, 1'b1, 3'd5},
        {4'b1111, 4'b1110, 3'd0, 1'b1, 3'd4}
    };

    localparam logic [3:0] SEQ [8] = '{4'b0000, 4'b0001, 4'b0011, 4'b0111,
                                       4'b1111, 4'b1110, 4'b1100, 4'b1000};

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic seed(input logic [3:0] pat);
        load_i = 1'b1;
        load_val_i = pat;
        en_i = 1'b0;
        tick();
        load_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        // R1: reset state
        chk("R1 count", {28'd0, count_o}, 32'd0);
        chk("R1 valid", {31'd0, valid_o}, 32'd1);
        chk("R1 dec", {24'd0, dec_o}, 32'd1);
        rst_i = 1'b0;

        // Table walk: every pattern (R5, R6, R7, R8)
        for (int i = 0; i < 16; i++) begin
            logic [3:0] st, nx;
            logic [2:0] steps, didx;
            logic       vld;
            int         taken;
            {st, nx, steps, vld, didx} = VEC[i];
            seed(st);
            chk("R5 load", {28'd0, count_o}, {28'd0, st});
            chk("R8 valid flag", {31'd0, valid_o}, {31'd0, vld});
            if (vld) chk("R7 decode", {24'd0, dec_o}, 32'd1 << didx);
            en_i = 1'b1;
            tick();
            chk("R6 next state", {28'd0, count_o}, {28'd0, nx});
            seed(st);
            en_i = 1'b1;
            taken = 0;
            while (!valid_o && taken < 8) begin
                tick();
                taken++;
            end
            en_i = 1'b0;
            chk("R6 steps to cycle", taken, {29'd0, steps});
        end

        // R3, R2, R9, R10: full cycle from reset, twice round
        rst_i = 1'b1;
        tick();
        rst_i = 1'b0;
        en_i = 1'b1;
        for (int c = 1; c <= 16; c++) begin
            logic [3:0] prev;
            prev = count_o;
            tick();
            chk("R3 sequence", {28'd0, count_o}, {28'd0, SEQ[c % 8]});
            chk("R9 one bit", $countones(count_o ^ prev), 32'd1);
            chk("R10 tap", {31'd0, div_o}, {31'd0, ((c % 8) >= 4) ? 1'b1 : 1'b0});
        end

        // R4: hold with enable low, outputs follow held state (state 0111)
        for (int c = 0; c < 3; c++) tick();
        en_i = 1'b0;
        for (int c = 0; c < 4; c++) begin
            tick();
            chk("R4 hold count", {28'd0, count_o}, 32'h7);
            chk("R4 hold dec", {24'd0, dec_o}, 32'h8);
        end

        // R5: load wins over enable
        load_i = 1'b1;
        load_val_i = 4'b1100;
        en_i = 1'b1;
        tick();
        load_i = 1'b0;
        en_i = 1'b0;
        chk("R5 load over enable", {28'd0, count_o}, 32'hC);
        chk("R7 decode 1100", {24'd0, dec_o}, 32'h40);

        // R1: reset wins over load
        rst_i = 1'b1;
        load_i = 1'b1;
        load_val_i = 4'b1001;
        tick();
        rst_i = 1'b0;
        load_i = 1'b0;
        chk("R1 reset over load", {28'd0, count_o}, 32'd0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule